// File: doc/BRIEF.md
# ECC Fault Status Flag Register

This block sits beside a memory read path and turns per-read error indications into two sticky fault flags that software can inspect and clear. Every time the read strobe is high, the block classifies the read: a corrected single-bit error, an uncorrectable double-bit error, or a collision. A collision is a read attempted while the memory controller is busy running a command, so the data returned is invalid.

A corrected error raises the single-fault flag. An uncorrectable error raises the double-fault flag. A collision raises both flags in the same cycle, and that pairing is the only way a collision is reported. The classified event passes through one capture register before it reaches the flags, so a fault shows up in the register one cycle after the read.

Software reaches the block through a byte-wide register port. Writes take effect at the clock edge and reads are combinational. The port holds a configuration register with a single-fault ignore bit and two interrupt enables, the write-one-to-clear fault status register, and a read-only view of the controller busy line. Each interrupt output is its fault flag gated by its enable.

Top module: `ecc_fault_status`

## Requirements
- R1: Address 1 is the fault status register. Bit 0 is the single-fault flag, bit 1 is the double-fault flag, and bits 7..2 always read 0.
- R2: Writing 1 to a status bit at address 1 clears that flag at the write edge. Writing 0 leaves the flag unchanged.
- R3: A read with `ecc_single`=1, `ecc_double`=0 and `mem_busy`=0 sets only the single-fault flag, provided the ignore bit is 0.
- R4: A read with `ecc_double`=1 and `mem_busy`=0 sets only the double-fault flag, even when `ecc_single` is also 1.
- R5: A read with `mem_busy`=1 sets both flags together, whatever the ECC inputs and the ignore bit are.
- R6: While the ignore bit (address 0, bit 0) is 1, a single-bit ECC fault does not set the single-fault flag.
- R7: A read sampled at clock edge N shows its flags in the status register only after edge N+1. Between edge N and edge N+1 the flags do not yet reflect it.
- R8: Address 2, bit 0 reads the current `mem_busy` level and bits 7..1 read 0. Writes to address 2 have no effect.
- R9: Reset clears both flags and the configuration register, and both interrupt outputs are 0.
- R10: If a flag's set and a clear of that flag arrive at the same edge, the flag ends up 1.
- R11: Address 0 holds the configuration: bit 0 is the ignore bit, bit 1 enables `irq_single`, bit 2 enables `irq_double`, and bits 7..3 read 0. Each interrupt output equals its flag ANDed with its enable.
- R12: When `rd_strobe` is 0, the fault and busy inputs have no effect on either flag.
- R13: Address 3 reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_strobe | input | 1 | A memory read is taking place this cycle |
| ecc_single | input | 1 | The read had a corrected single-bit error |
| ecc_double | input | 1 | The read had an uncorrectable double-bit error |
| mem_busy | input | 1 | The memory controller is executing a command |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| irq_single | output | 1 | Single-fault interrupt |
| irq_double | output | 1 | Double-fault interrupt |

## Verification
The interesting same-cycle overlap is a fault event landing in the flag register at the very edge where software writes a clear of that flag. The bench provokes it on purpose by issuing a write-one-to-clear exactly one cycle after a faulting read, so that the write and the delayed set meet at the same edge. It also provokes it at random by mixing reads and status writes densely. A behavioural model holds the pending event in a queue. The model is compared against the register read data and both interrupt outputs on every clock, and it expects the flag to survive the overlap.

// File: rtl/ecc_flt_pkg.sv
`timescale 1ns/1ps
package ecc_flt_pkg;

   // classified fault event, one bit per flag
   typedef struct packed {
      logic dbl;
      logic sgl;
   } flt_evt_t;

   localparam int unsigned FLT_SGL_BIT = 0;
   localparam int unsigned FLT_DBL_BIT = 1;
   localparam int unsigned FLT_NUM     = 2;

   // configuration field positions
   localparam int unsigned CFG_IGN_BIT  = 0;
   localparam int unsigned CFG_ENS_BIT  = 1;
   localparam int unsigned CFG_END_BIT  = 2;
   localparam int unsigned CFG_W        = 3;

   localparam flt_evt_t FLT_NONE = '{dbl: 1'b0, sgl: 1'b0};

   function automatic logic [FLT_NUM-1:0] evt_to_vec(input flt_evt_t e);
      logic [FLT_NUM-1:0] v;
      v = '0;
      v[FLT_SGL_BIT] = e.sgl;
      v[FLT_DBL_BIT] = e.dbl;
      return v;
   endfunction

endpackage

// File: rtl/ecc_flt_classify.sv
`timescale 1ns/1ps
module ecc_flt_classify
   import ecc_flt_pkg::*;
(
   input  logic     rd_strobe,
   input  logic     ecc_single,
   input  logic     ecc_double,
   input  logic     mem_busy,
   input  logic     ignore_single,
   output flt_evt_t evt
);

   logic collide;
   logic true_dbl;
   logic true_sgl;

   always_comb begin
      collide  = rd_strobe & mem_busy;
      true_dbl = rd_strobe & ~mem_busy & ecc_double;
      true_sgl = rd_strobe & ~mem_busy & ~ecc_double & ecc_single & ~ignore_single;
      evt.dbl  = collide | true_dbl;
      evt.sgl  = collide | true_sgl;
   end

endmodule

// File: rtl/ecc_flt_pipe.sv
`timescale 1ns/1ps
module ecc_flt_pipe
   import ecc_flt_pkg::*;
#(
   parameter int unsigned STAGES = 1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  flt_evt_t evt_i,
   output flt_evt_t evt_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign evt_o = evt_i;
      end else begin : g_stages
         flt_evt_t sr [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_st
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  sr[s] <= FLT_NONE;
               end else if (s == 0) begin
                  sr[s] <= evt_i;
               end else begin
                  sr[s] <= sr[(s == 0) ? 0 : s-1];
               end
            end
         end
         assign evt_o = sr[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/ecc_flt_flag.sv
`timescale 1ns/1ps
module ecc_flt_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_o <= 1'b0;
      else        flag_o <= set_i | (flag_o & ~clr_i);
   end

   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o); // R10
   AST_ZERO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o); // R2
   AST_ONE_WRITE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o); // R2

endmodule

// File: rtl/ecc_flt_regs.sv
`timescale 1ns/1ps
module ecc_flt_regs
   import ecc_flt_pkg::*;
#(
   parameter int unsigned REG_W     = 8,
   parameter int unsigned ADDR_W    = 2,
   parameter int unsigned CFG_ADDR  = 0,
   parameter int unsigned STAT_ADDR = 1,
   parameter int unsigned BUSY_ADDR = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [REG_W-1:0]   reg_wdata,
   input  logic [FLT_NUM-1:0] flags,
   input  logic               mem_busy,
   output logic [REG_W-1:0]   reg_rdata,
   output logic [FLT_NUM-1:0] clr,
   output logic [CFG_W-1:0]   cfg
);

   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_ADDR);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] A_BUSY = ADDR_W'(BUSY_ADDR);

   logic sel_cfg, sel_stat, sel_busy;
   logic unused_wbits;

   assign sel_cfg  = (reg_addr == A_CFG);
   assign sel_stat = (reg_addr == A_STAT);
   assign sel_busy = (reg_addr == A_BUSY);
   assign unused_wbits = ^reg_wdata[REG_W-1:CFG_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cfg <= '0;
      else if (reg_wr && sel_cfg) cfg <= reg_wdata[CFG_W-1:0];
   end

   always_comb begin
      clr = '0;
      if (reg_wr && sel_stat) clr = reg_wdata[FLT_NUM-1:0];
   end

   always_comb begin
      reg_rdata = '0;
      if (sel_cfg)       reg_rdata[CFG_W-1:0]   = cfg;
      else if (sel_stat) reg_rdata[FLT_NUM-1:0] = flags;
      else if (sel_busy) reg_rdata[0]           = mem_busy;
   end

   AST_CFG_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && sel_cfg) |=> $stable(cfg)); // R11
   AST_NO_CLEAR_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |-> (clr == '0)); // R2

endmodule

// File: rtl/ecc_fault_status.sv
`timescale 1ns/1ps
module ecc_fault_status
   import ecc_flt_pkg::*;
#(
   parameter int unsigned REG_W          = 8,
   parameter int unsigned ADDR_W         = 2,
   parameter int unsigned CFG_ADDR       = 0,
   parameter int unsigned STAT_ADDR      = 1,
   parameter int unsigned BUSY_ADDR      = 2,
   parameter int unsigned CAPTURE_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_strobe,
   input  logic              ecc_single,
   input  logic              ecc_double,
   input  logic              mem_busy,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              irq_single,
   output logic              irq_double
);

   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   generate
      if (REG_W < CFG_W) begin : g_chk_w
         $error("ecc_fault_status: REG_W too narrow for config fields");
      end
      if (CFG_ADDR >= ADDR_SPAN || STAT_ADDR >= ADDR_SPAN || BUSY_ADDR >= ADDR_SPAN) begin : g_chk_a
         $error("ecc_fault_status: register address outside ADDR_W span");
      end
      if (CFG_ADDR == STAT_ADDR || CFG_ADDR == BUSY_ADDR || STAT_ADDR == BUSY_ADDR) begin : g_chk_u
         $error("ecc_fault_status: register addresses must differ");
      end
      if (CAPTURE_STAGES > 4) begin : g_chk_s
         $error("ecc_fault_status: CAPTURE_STAGES limited to 4");
      end
   endgenerate

   flt_evt_t           evt_now, evt_late;
   logic [FLT_NUM-1:0] set_v, clr_v, flags;
   logic [CFG_W-1:0]   cfg;

   ecc_flt_classify u_cls (
      .rd_strobe    (rd_strobe),
      .ecc_single   (ecc_single),
      .ecc_double   (ecc_double),
      .mem_busy     (mem_busy),
      .ignore_single(cfg[CFG_IGN_BIT]),
      .evt          (evt_now)
   );

   ecc_flt_pipe #(.STAGES(CAPTURE_STAGES)) u_pipe (
      .clk  (clk),
      .rst_n(rst_n),
      .evt_i(evt_now),
      .evt_o(evt_late)
   );

   assign set_v = evt_to_vec(evt_late);

   generate
      for (genvar f = 0; f < FLT_NUM; f++) begin : g_flag
         ecc_flt_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_v[f]),
            .clr_i (clr_v[f]),
            .flag_o(flags[f])
         );
      end
   endgenerate

   ecc_flt_regs #(
      .REG_W    (REG_W),
      .ADDR_W   (ADDR_W),
      .CFG_ADDR (CFG_ADDR),
      .STAT_ADDR(STAT_ADDR),
      .BUSY_ADDR(BUSY_ADDR)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .flags    (flags),
      .mem_busy (mem_busy),
      .reg_rdata(reg_rdata),
      .clr      (clr_v),
      .cfg      (cfg)
   );

   assign irq_single = flags[FLT_SGL_BIT] & cfg[CFG_ENS_BIT];
   assign irq_double = flags[FLT_DBL_BIT] & cfg[CFG_END_BIT];

   AST_SGL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[FLT_SGL_BIT]) |-> $past(rd_strobe && (mem_busy ||
         (ecc_single && !ecc_double && !cfg[CFG_IGN_BIT])), CAPTURE_STAGES+1)); // R6
   AST_DBL_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[FLT_DBL_BIT]) |-> $past(rd_strobe && (mem_busy || ecc_double),
         CAPTURE_STAGES+1)); // R12

   generate
      if (CAPTURE_STAGES == 1) begin : g_lat_chk
         AST_COLLIDE_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_strobe && mem_busy) |-> ##2 (flags == 2'b11)); // R5
      end
   endgenerate

endmodule

// File: tb/test_ecc_fault_status.sv
`timescale 1ns/1ps
module test_ecc_fault_status;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rd_strobe = 0, ecc_single = 0, ecc_double = 0, mem_busy = 0;
   logic       reg_wr = 0;
   logic [1:0] reg_addr = 0;
   logic [7:0] reg_wdata = 0;
   logic [7:0] reg_rdata;
   logic       irq_single, irq_double;

   ecc_fault_status i_ecc_fault_status (
      .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .ecc_single(ecc_single),
      .ecc_double(ecc_double), .mem_busy(mem_busy), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_single(irq_single), .irq_double(irq_double)
   );

   always #4 clk = ~clk;

   int    n_vec = 0;
   int    n_bad = 0;
   string cur_req = "R9";
   bit    done = 0;

   // behavioural reference
   logic [1:0] m_flags = 0;
   logic [2:0] m_cfg = 0;
   logic [1:0] evq[$];

   initial evq.push_back(2'b00);

   always @(posedge clk) begin
      if (!rst_n) begin
         m_flags = 0;
         m_cfg   = 0;
         evq.delete();
         evq.push_back(2'b00);
      end else begin
         logic [1:0] clr, ev, landed;
         clr = (reg_wr && reg_addr == 2'd1) ? reg_wdata[1:0] : 2'b00;
         ev  = 2'b00;
         if (rd_strobe) begin
            if (mem_busy)                    ev = 2'b11;
            else if (ecc_double)             ev = 2'b10;
            else if (ecc_single && !m_cfg[0]) ev = 2'b01;
         end
         landed  = evq.pop_front();
         m_flags = (m_flags & ~clr) | landed;
         evq.push_back(ev);
         if (reg_wr && reg_addr == 2'd0) m_cfg = reg_wdata[2:0];
      end
   end

   task automatic check(input bit ok, input string what, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [7:0] exp_rd;
         case (reg_addr)
            2'd0:    exp_rd = {5'b0, m_cfg};
            2'd1:    exp_rd = {6'b0, m_flags};
            2'd2:    exp_rd = {7'b0, mem_busy};
            default: exp_rd = 8'h00;
         endcase
         check(reg_rdata == exp_rd, "rdata", reg_rdata, exp_rd);
         check(irq_single == (m_flags[0] & m_cfg[1]), "irq_single", irq_single, m_flags[0] & m_cfg[1]);
         check(irq_double == (m_flags[1] & m_cfg[2]), "irq_double", irq_double, m_flags[1] & m_cfg[2]);
      end
   end

   task automatic drive(input logic rd, input logic s, input logic d, input logic b,
                        input logic wr, input logic [1:0] a, input logic [7:0] wd);
      @(posedge clk); #2;
      rd_strobe = rd; ecc_single = s; ecc_double = d; mem_busy = b;
      reg_wr = wr; reg_addr = a; reg_wdata = wd;
   endtask

   task automatic idle(input logic [1:0] a, input int n);
      for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, a, 8'h00);
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] wd);
      drive(0, 0, 0, 0, 1, a, wd);
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog expired, %s", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #21 rst_n = 1'b1;
      cur_req = "R9";
      idle(2'd1, 1); #3;
      check(reg_rdata == 8'h00 && !irq_single && !irq_double, "post-reset", reg_rdata, 0);
      idle(2'd0, 2);

      cur_req = "R11";
      wr_reg(2'd0, 8'hFE); idle(2'd0, 2);
      cur_req = "R3";
      drive(1, 1, 0, 0, 0, 2'd1, 0);
      cur_req = "R7";
      idle(2'd1, 1); #3;
      check(reg_rdata[0] == 1'b0, "flag early", reg_rdata, 0);
      idle(2'd1, 1); #3;
      check(reg_rdata == 8'h01 && irq_single, "flag late", reg_rdata, 1);
      cur_req = "R2";
      wr_reg(2'd1, 8'hFC); idle(2'd1, 2);
      wr_reg(2'd1, 8'h01); idle(2'd1, 2);
      cur_req = "R4";
      drive(1, 1, 1, 0, 0, 2'd1, 0); idle(2'd1, 3);
      cur_req = "R1";
      wr_reg(2'd1, 8'hFF); idle(2'd1, 2);
      cur_req = "R6";
      wr_reg(2'd0, 8'h07); drive(1, 1, 0, 0, 0, 2'd1, 0); idle(2'd1, 3);
      cur_req = "R5";
      drive(1, 1, 0, 1, 0, 2'd1, 0); idle(2'd1, 3);
      wr_reg(2'd1, 8'h03); drive(1, 0, 0, 1, 0, 2'd1, 0); idle(2'd1, 3);
      cur_req = "R10";
      wr_reg(2'd1, 8'h03); wr_reg(2'd0, 8'h06);
      drive(1, 1, 0, 0, 0, 2'd1, 0); wr_reg(2'd1, 8'h01); idle(2'd1, 2);
      drive(1, 0, 1, 0, 0, 2'd1, 0); wr_reg(2'd1, 8'h02); idle(2'd1, 2);
      cur_req = "R12";
      wr_reg(2'd1, 8'h03);
      for (int i = 0; i < 8; i++) drive(0, i[0], i[1], i[2], 0, 2'd1, 0);
      idle(2'd1, 3);
      cur_req = "R8";
      drive(0, 0, 0, 1, 0, 2'd2, 0); drive(0, 0, 0, 0, 0, 2'd2, 0);
      drive(0, 0, 0, 1, 1, 2'd2, 8'hFF); idle(2'd0, 2);
      cur_req = "R13";
      wr_reg(2'd3, 8'hFF); idle(2'd3, 1); idle(2'd0, 1); idle(2'd1, 1);

      cur_req = "random mix";
      for (int i = 0; i < 4000; i++) begin
         logic [7:0] r;
         r = 8'($urandom);
         drive(r[0], r[1], r[2] & r[3], (r[4:6] == 3'b111),
               ($urandom_range(0, 5) == 0), 2'($urandom), 8'($urandom));
      end
      idle(2'd1, 3);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule